// File: doc/BRIEF.md
# Boost Rectifier Start-Up Sequencer

This block brings a boost power-factor-correction front end from off to regulated operation. Once enabled, it first measures the half-cycle period of the rectified line from a zero-crossing strobe, counted in ticks of a slow time base. From that measurement it predicts the next crossing. It then drives the inrush-bypass relay early by a fixed actuation delay, so that the contacts make at the crossing and not at a voltage peak.

After the relay has made, the sequencer waits for one more crossing. It then starts the PWM clock and selects a fixed preset peak-current command, which the downstream multiplier scales by the line phase. It stays in that soft-start phase until the bulk-voltage comparator reports the nominal level. It then hands the peak command to the normal voltage loop and raises a run flag. If the bulk voltage never arrives, a soft-start timeout ends in a latched fault with relay and PWM dropped. Removing enable always returns the sequencer to idle with every drive off.

All outputs are registered and change on the same clock edge as the state.

Top module: `boost_startup_seq`

## Requirements
- R1: While reset is high, and on the first edge after reset with enable low, seq_state reads 0 and relay_drive, peak_cmd_preset, pwm_clk_en, run_flag and fault_flag are all 0. seq_state codes are: 0 idle, 1 waiting for relay slot, 2 relay settling, 3 waiting for crossing, 4 soft start, 5 run, 6 fault.
- R2: enable high in idle moves the state to 1 on the next edge. enable low in any state returns the state to 0 on the next edge with all drives off, whatever else is sampled on that edge.
- R3: A half-cycle period becomes valid only after two zero-crossing strobes have been sampled while enable is high since enable last rose. The period is the number of time_tick cycles counted between them. The count advances only in cycles with time_tick high.
- R4: In state 1, relay_drive rises on the edge after the tick count since the last crossing plus RELAY_DELAY reaches the measured period. With time_tick high every cycle, this is RELAY_DELAY clock edges before the edge that samples the next crossing. Relay drive is never issued from a cycle that carries a crossing strobe.
- R5: If the measured period is no more than RELAY_DELAY, relay_drive rises on the second edge after the crossing that completed the measurement.
- R6: In state 2, a crossing moves the state to 3. In state 3, a crossing moves it to 4, where relay_drive, pwm_clk_en and peak_cmd_preset are 1 and run_flag is 0.
- R7: bulk_at_ref high in state 4 moves the state to 5, with run_flag, relay_drive and pwm_clk_en at 1 and peak_cmd_preset at 0. State 5 then ignores crossings and the bulk flag.
- R8: After exactly SS_TIMEOUT edges in state 4 without bulk_at_ref, the state becomes 6 with fault_flag 1 and every other drive 0. State 6 ignores bulk_at_ref until enable falls.
- R9: When bulk_at_ref is sampled on the same edge at which the soft-start timeout expires, the state goes to 5, not 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Start request; low forces idle |
| zc_strobe | input | 1 | One-cycle pulse at each line zero crossing |
| time_tick | input | 1 | Time-base tick for half-cycle measurement |
| bulk_at_ref | input | 1 | Bulk voltage has reached nominal reference |
| relay_drive | output | 1 | Inrush-bypass relay coil drive |
| peak_cmd_preset | output | 1 | 1 selects the fixed preset peak-current command |
| pwm_clk_en | output | 1 | Enables the interleaved PWM clock |
| run_flag | output | 1 | Normal regulation active |
| fault_flag | output | 1 | Soft-start timeout fault latched |
| seq_state | output | 3 | Sequencer state code |

## Verification
Two events can land on the same edge in soft start: the bulk-voltage flag arriving, and the timeout counter reaching its limit. The bench reaches soft start, waits one edge short of the limit, and raises the bulk flag for exactly the expiry edge. The result is judged by seq_state reading 5 and fault_flag staying low. A second collision pairs an enable drop with a bulk flag in soft start, and idle must win.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_WAIT_SLOT = 3'd1,
    ST_SETTLE    = 3'd2,
    ST_WAIT_ZC   = 3'd3,
    ST_SOFT      = 3'd4,
    ST_RUN       = 3'd5,
    ST_FAULT     = 3'd6
  } seq_state_t;

  typedef struct packed {
    logic relay;
    logic preset;
    logic pwm;
    logic run;
    logic fault;
  } seq_drive_t;

  function automatic seq_drive_t drive_for(seq_state_t s);
    seq_drive_t d;
    d = '0;
    case (s)
      ST_SETTLE, ST_WAIT_ZC: d.relay = 1'b1;
      ST_SOFT: begin
        d.relay  = 1'b1;
        d.pwm    = 1'b1;
        d.preset = 1'b1;
      end
      ST_RUN: begin
        d.relay = 1'b1;
        d.pwm   = 1'b1;
        d.run   = 1'b1;
      end
      ST_FAULT: d.fault = 1'b1;
      default: d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/zc_slot_predictor.sv
module zc_slot_predictor #(
  parameter int TIMER_W     = 12,
  parameter int RELAY_DELAY = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic tick,
  input  logic zc,
  output logic fire
);
  localparam logic [TIMER_W:0] DLY_EXT = (TIMER_W + 1)'(RELAY_DELAY);

  logic [TIMER_W-1:0] timer_q;
  logic [TIMER_W-1:0] period_q;
  logic               seen_q;
  logic               valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      timer_q  <= '0;
      period_q <= '0;
      seen_q   <= 1'b0;
      valid_q  <= 1'b0;
    end else if (zc) begin
      timer_q  <= '0;
      period_q <= timer_q;
      seen_q   <= enable;
      valid_q  <= enable && seen_q;
    end else begin
      if (tick && (timer_q != '1)) timer_q <= timer_q + 1'b1;
      if (!enable) begin
        seen_q  <= 1'b0;
        valid_q <= 1'b0;
      end
    end
  end

  // predicted crossing lies within RELAY_DELAY ticks of the current count
  always_comb begin
    fire = valid_q && !zc &&
           (({1'b0, timer_q} + DLY_EXT) >= {1'b0, period_q});
  end

  // R3: count frozen when no tick and no crossing
  p_hold_without_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick && !zc) |=> (timer_q == $past(timer_q)));

  // R3: a single crossing never yields a valid period
  p_one_crossing_not_valid_r3: assert property (@(posedge clk) disable iff (rst)
    (zc && !seen_q) |=> !valid_q);

endmodule

// File: rtl/softstart_timer.sv
module softstart_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !active)      cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  always_comb expired = active && (cnt_q == LAST);

endmodule

// File: rtl/startup_fsm.sv
module startup_fsm
  import startup_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       zc,
  input  logic       bulk_ok,
  input  logic       fire,
  input  logic       expired,
  output seq_state_t state_q,
  output seq_drive_t drv_q
);
  seq_state_t state_n;

  always_comb begin
    state_n = state_q;
    if (!enable) begin
      state_n = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:      state_n = ST_WAIT_SLOT;
        ST_WAIT_SLOT: if (fire) state_n = ST_SETTLE;
        ST_SETTLE:    if (zc)   state_n = ST_WAIT_ZC;
        ST_WAIT_ZC:   if (zc)   state_n = ST_SOFT;
        ST_SOFT: begin
          if (bulk_ok)      state_n = ST_RUN;
          else if (expired) state_n = ST_FAULT;
        end
        ST_RUN:       state_n = ST_RUN;
        ST_FAULT:     state_n = ST_FAULT;
        default:      state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      drv_q   <= '0;
    end else begin
      state_q <= state_n;
      drv_q   <= drive_for(state_n);
    end
  end

  p_disable_to_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (state_q == ST_IDLE));

  p_relay_follows_fire_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_q.relay) |-> $past(fire));

  p_soft_on_crossing_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_q.pwm) |-> $past(zc));

  p_run_needs_bulk_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_q.run) |-> $past(bulk_ok));

  p_fault_after_expiry_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(drv_q.fault) |-> ($past(expired) && !$past(bulk_ok)));

endmodule

// File: rtl/boost_startup_seq.sv
module boost_startup_seq
  import startup_seq_pkg::*;
#(
  parameter int TIMER_W     = 12,
  parameter int RELAY_DELAY = 5,
  parameter int SS_TIMEOUT  = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       zc_strobe,
  input  logic       time_tick,
  input  logic       bulk_at_ref,
  output logic       relay_drive,
  output logic       peak_cmd_preset,
  output logic       pwm_clk_en,
  output logic       run_flag,
  output logic       fault_flag,
  output logic [2:0] seq_state
);
  logic       slot_fire;
  logic       ss_expired;
  seq_state_t state_w;
  seq_drive_t drv_w;

  zc_slot_predictor #(
    .TIMER_W     (TIMER_W),
    .RELAY_DELAY (RELAY_DELAY)
  ) u_pred (
    .clk    (clk),
    .rst    (rst),
    .enable (enable),
    .tick   (time_tick),
    .zc     (zc_strobe),
    .fire   (slot_fire)
  );

  softstart_timer #(
    .LIMIT (SS_TIMEOUT)
  ) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .active  (state_w == ST_SOFT),
    .expired (ss_expired)
  );

  startup_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .enable  (enable),
    .zc      (zc_strobe),
    .bulk_ok (bulk_at_ref),
    .fire    (slot_fire),
    .expired (ss_expired),
    .state_q (state_w),
    .drv_q   (drv_w)
  );

  assign seq_state       = state_w;
  assign relay_drive     = drv_w.relay;
  assign peak_cmd_preset = drv_w.preset;
  assign pwm_clk_en      = drv_w.pwm;
  assign run_flag        = drv_w.run;
  assign fault_flag      = drv_w.fault;

endmodule

// File: tb/boost_startup_seq_test.sv
module boost_startup_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int SS_TO      = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, zc = 1'b0, tick = 1'b1, bulk = 1'b0;
  logic relay, preset, pwm, run, fault;
  logic [2:0] st;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boost_startup_seq uut (
    .clk(clk), .rst(rst), .enable(en), .zc_strobe(zc), .time_tick(tick),
    .bulk_at_ref(bulk), .relay_drive(relay), .peak_cmd_preset(preset),
    .pwm_clk_en(pwm), .run_flag(run), .fault_flag(fault), .seq_state(st)
  );

  // {state, relay, preset, pwm, run, fault} expected for a state code
  function automatic logic [7:0] exp_vec(logic [2:0] s);
    case (s)
      3'd2, 3'd3: return {s, 5'b10000};
      3'd4:       return {s, 5'b11100};
      3'd5:       return {s, 5'b10110};
      3'd6:       return {s, 5'b00001};
      default:    return {s, 5'b00000};
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(logic [2:0] exp_s, string tag);
    logic [7:0] act, exp;
    act = {st, relay, preset, pwm, run, fault};
    exp = exp_vec(exp_s);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic pulse_zc();
    zc = 1'b1; step(); zc = 1'b0;
  endtask

  task automatic go_soft();
    en = 1'b1; bulk = 1'b0; tick = 1'b1; step();
    pulse_zc(); repeat (19) step();
    pulse_zc(); repeat (19) step();
    pulse_zc(); repeat (19) step();
    pulse_zc();
  endtask

  // fields: {en, zc, bulk, idle[7:0], exp_state[2:0]}
  localparam logic [13:0] TBL [14] = '{
    {1'b1, 1'b0, 1'b0, 8'd0,  3'd1},
    {1'b1, 1'b1, 1'b0, 8'd0,  3'd1},
    {1'b1, 1'b0, 1'b0, 8'd18, 3'd1},
    {1'b1, 1'b1, 1'b0, 8'd0,  3'd1},
    {1'b1, 1'b0, 1'b0, 8'd13, 3'd1},
    {1'b1, 1'b0, 1'b0, 8'd0,  3'd2},
    {1'b1, 1'b0, 1'b0, 8'd3,  3'd2},
    {1'b1, 1'b1, 1'b0, 8'd0,  3'd3},
    {1'b1, 1'b0, 1'b0, 8'd18, 3'd3},
    {1'b1, 1'b1, 1'b0, 8'd0,  3'd4},
    {1'b1, 1'b0, 1'b0, 8'd9,  3'd4},
    {1'b1, 1'b0, 1'b1, 8'd0,  3'd5},
    {1'b1, 1'b1, 1'b0, 8'd0,  3'd5},
    {1'b0, 1'b0, 1'b0, 8'd0,  3'd0}
  };

  initial begin
    repeat (3) step();
    check(3'd0, "R1 during reset");
    rst = 1'b0; step();
    check(3'd0, "R1 after reset");

    // main sequence: R2 R4 R6 R7, crossings 20 ticks apart, relay 5 early
    for (int i = 0; i < 14; i++) begin
      en = TBL[i][13]; zc = TBL[i][12]; bulk = TBL[i][11];
      step();
      zc = 1'b0;
      repeat (int'(TBL[i][10:3])) step();
      check(TBL[i][2:0], $sformatf("table row %0d (R2 R4 R6 R7)", i));
    end

    // R8 timeout and fault hold
    en = 1'b0; step();
    go_soft();
    check(3'd4, "R6 reached soft start");
    repeat (SS_TO - 1) step();
    check(3'd4, "R8 one edge before timeout");
    step();
    check(3'd6, "R8 timeout fault");
    bulk = 1'b1; repeat (4) step();
    check(3'd6, "R8 fault ignores bulk");
    en = 1'b0; bulk = 1'b0; step();
    check(3'd0, "R2 fault cleared by enable");

    // R9 bulk and timeout on same edge
    go_soft();
    repeat (SS_TO - 1) step();
    bulk = 1'b1; step();
    check(3'd5, "R9 bulk wins over timeout");
    bulk = 1'b0; en = 1'b0; step();
    check(3'd0, "R2 run to idle");

    // R2 enable drop beats bulk in soft start
    go_soft();
    bulk = 1'b1; en = 1'b0; step();
    check(3'd0, "R2 disable beats bulk");
    bulk = 1'b0;

    // R3 one crossing only, stale period discarded
    en = 1'b1; step();
    pulse_zc();
    repeat (30) step();
    check(3'd1, "R3 single crossing no relay");
    pulse_zc();              // period = 30 ticks
    tick = 1'b0;
    repeat (50) step();
    check(3'd1, "R3 no ticks no progress");
    tick = 1'b1;
    repeat (25) step();
    check(3'd1, "R4 one edge before slot");
    step();
    check(3'd2, "R4 relay at slot");

    // R5 period shorter than relay delay
    en = 1'b0; step();
    en = 1'b1; step();
    pulse_zc();
    repeat (2) step();
    pulse_zc();
    check(3'd1, "R4 no relay on crossing cycle");
    step();
    check(3'd2, "R5 short period immediate relay");
    en = 1'b0; step();
    check(3'd0, "R2 final idle");

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule